// File: doc/BRIEF.md
# Flag-Setting ALU with Shift-Carry Flags

This block is a 32-bit integer execute stage. Operand B first passes through a left shift by an immediate amount. The shifted value is then combined with operand A by one of five operations: bitwise AND, bitwise OR, bitwise exclusive-OR, addition or subtraction. The result is combinational. A four-bit condition register holds the negative, zero, carry and overflow flags. It is written on the rising clock edge only when the set-flags input is high.

The arithmetic operations always write all four flags. The logical operations always write negative and zero, but how they treat carry and overflow depends on a mode pin. In the legacy mode, overflow keeps its old value. Carry takes the last bit that the shifter pushed out of operand B, or keeps its old value when the shift amount is zero. In the wide mode, a logical operation forces both carry and overflow to zero. This removes any dependence on the previous flags.

The block has no data handshake. The operands are consumed in the same cycle they are presented, so valid/ready would add nothing. The control pins are plain levels.

Top module: `flag_alu`

## Requirements
- R1: `result` equals A op (B << shamt), with opcode 0 = AND, 1 = OR, 2 = XOR, 3 = ADD, 4 = SUB (A minus shifted B). Opcodes 5 to 7 behave as AND. `result` is combinational.
- R2: On a clock edge with `set_flags` high, N takes bit 31 of the result and Z is set exactly when the result is zero. This applies to every opcode.
- R3: For ADD with `set_flags` high, C takes the carry out of bit 31. V is set when both addends have the same sign and the sum's sign differs from it.
- R4: For SUB with `set_flags` high, C is 1 when no borrow occurs (A >= shifted B, unsigned). V is set when the operands' signs differ and the result's sign differs from A's sign.
- R5: For a logical opcode with `wide_mode` = 0 and a nonzero shift n, C takes bit (32 - n) of the unshifted B.
- R6: For a logical opcode with `wide_mode` = 0 and a shift of zero, C keeps its previous value.
- R7: For a logical opcode with `wide_mode` = 0, V keeps its previous value.
- R8: For a logical opcode with `wide_mode` = 1, C and V are both written to 0, whatever the shift.
- R9: With `set_flags` low, all four flags keep their values on the clock edge.
- R10: An active-low `rst_n` clears all four flags to 0. The flag register changes only on the rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, shifted before use |
| shamt | input | 5 | Left-shift amount applied to op_b |
| opcode | input | 3 | Operation select (see R1) |
| set_flags | input | 1 | Write enable for the flag register |
| wide_mode | input | 1 | 0: legacy logical-flag rules, 1: logical ops clear C and V |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions inside the flag register check four rules on every cycle:
- The register holds when the write enable is low.
- N and Z follow the result that was presented.
- Overflow, and carry at zero shift, are preserved for legacy-mode logical operations.
- C and V are cleared for wide-mode logical operations.

Only the bench's scenarios can show that values are correct:
- the result of each opcode with a shifted operand;
- the exact carry and overflow from additions and subtractions;
- which operand bit becomes the shifter carry at shift amounts 4, 5 and 31;
- the flag values across a chain of operations that rely on earlier state.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHIFT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_ORR = 3'd1,
    OP_EOR = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_flags_t;
endpackage

// File: rtl/imm_lsl_shifter.sv
module imm_lsl_shifter #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amount,
  output logic [W-1:0]   dout,
  output logic           carry_out,
  output logic           amount_nz
);
  logic [W:0] widened;

  always_comb begin
    widened   = {1'b0, din} << amount;
    dout      = widened[W-1:0];
    carry_out = widened[W];
    amount_nz = |amount;
  end

  // R5
  always_comb begin
    if (amount_nz) begin
      shift_carry_chk: assert (carry_out == din[W - 32'(amount)]);
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         arith_c,
  output logic         arith_v,
  output logic         is_logic
);
  logic         do_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_ext;

  always_comb begin
    do_sub  = (op == OP_SUB);
    b_eff   = do_sub ? ~b : b;
    sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
    arith_c = sum_ext[W];
    arith_v = (a[W-1] == b_eff[W-1]) && (sum_ext[W-1] != a[W-1]);
    is_logic = !(op == OP_ADD || op == OP_SUB);
    case (op)
      OP_ORR:         y = a | b;
      OP_EOR:         y = a ^ b;
      OP_ADD, OP_SUB: y = sum_ext[W-1:0];
      default:        y = a & b;
    endcase
  end
endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import flag_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_en,
  input  logic        wide,
  input  logic        is_logic,
  input  logic        sh_nz,
  input  logic        sh_carry,
  input  logic        res_msb,
  input  logic        res_zero,
  input  logic        ar_c,
  input  logic        ar_v,
  output cond_flags_t q
);
  cond_flags_t nxt;

  always_comb begin
    nxt   = q;
    nxt.n = res_msb;
    nxt.z = res_zero;
    if (!is_logic) begin
      nxt.c = ar_c;
      nxt.v = ar_v;
    end else if (wide) begin
      nxt.c = 1'b0;
      nxt.v = 1'b0;
    end else if (sh_nz) begin
      nxt.c = sh_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= nxt;
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(q));

  // R2
  nz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (q.n == $past(res_msb)) && (q.z == $past(res_zero)));

  // R7
  v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && is_logic && !wide) |=> $stable(q.v));

  // R6
  c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && is_logic && !wide && !sh_nz) |=> $stable(q.c));

  // R8
  wide_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && is_logic && wide) |=> (!q.c && !q.v));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned W   = DATA_W,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [SHW-1:0] shamt,
  input  logic [2:0]     opcode,
  input  logic           set_flags,
  input  logic           wide_mode,
  output logic [W-1:0]   result,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_v
);
  logic [W-1:0] b_shifted;
  logic         sh_carry;
  logic         sh_nz;
  logic         ar_c;
  logic         ar_v;
  logic         is_logic;
  cond_flags_t  flags_q;

  imm_lsl_shifter #(.W(W), .SHW(SHW)) u_shift (
    .din       (op_b),
    .amount    (shamt),
    .dout      (b_shifted),
    .carry_out (sh_carry),
    .amount_nz (sh_nz)
  );

  alu_core #(.W(W)) u_core (
    .a        (op_a),
    .b        (b_shifted),
    .op       (alu_op_e'(opcode)),
    .y        (result),
    .arith_c  (ar_c),
    .arith_v  (ar_v),
    .is_logic (is_logic)
  );

  cond_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_flags),
    .wide     (wide_mode),
    .is_logic (is_logic),
    .sh_nz    (sh_nz),
    .sh_carry (sh_carry),
    .res_msb  (result[W-1]),
    .res_zero (result == '0),
    .ar_c     (ar_c),
    .ar_v     (ar_v),
    .q        (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (flags_q == '0));
endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [3:0]  nzcv;
  } vec_t;

  // Chained: each row's expected flags depend on the row before it.
  localparam vec_t VECS [NVEC] = '{
    '{3'd3, 1'b0, 5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 4'b1001}, // R3 overflow
    '{3'd0, 1'b0, 5'd0, 32'h0000_C5BF, 32'h0000_0000, 32'h0000_0000, 4'b0101}, // R6 R7 keep C,V
    '{3'd4, 1'b0, 5'd0, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 4'b0110}, // R4 no borrow
    '{3'd3, 1'b0, 5'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 4'b0111}, // R3 carry+ovf
    '{3'd0, 1'b0, 5'd5, 32'hFFFF_FFFF, 32'h0800_0001, 32'h0000_0020, 4'b0011}, // R5 bit27
    '{3'd2, 1'b0, 5'd4, 32'h0000_0000, 32'h0F00_0000, 32'hF000_0000, 4'b1001}, // R5 bit28=0
    '{3'd1, 1'b1, 5'd0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 4'b1000}, // R8 clear V
    '{3'd3, 1'b0, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b0110}, // R3 carry
    '{3'd1, 1'b0, 5'd0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 4'b0010}, // R6 keep C=1
    '{3'd4, 1'b0, 5'd0, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 4'b0011}, // R4 ovf
    '{3'd2, 1'b1, 5'd3, 32'h0000_0000, 32'hE000_0000, 32'h0000_0000, 4'b0100}, // R8 clear C
    '{3'd4, 1'b0, 5'd0, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 4'b1000}, // R4 borrow
    '{3'd3, 1'b0, 5'd1, 32'h0000_0000, 32'h4000_0000, 32'h8000_0000, 4'b1000}  // R1 shifted add
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [4:0]  shamt = '0;
  logic [2:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic        wide_mode = 1'b0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .shamt(shamt),
    .opcode(opcode), .set_flags(set_flags), .wide_mode(wide_mode),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  function automatic logic [3:0] nzcv();
    return {flag_n, flag_z, flag_c, flag_v};
  endfunction

  task automatic check_res(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [3:0] exp);
    checks++;
    if (nzcv() !== exp) begin
      fails++;
      $display("FAIL %s nzcv actual=%b expected=%b", req, nzcv(), exp);
    end
  endtask

  // Drive at negedge, check result, let one rising edge pass, check flags.
  task automatic run_op(input logic [2:0] op, input logic wd, input logic [4:0] sh,
                        input logic [31:0] a, input logic [31:0] b, input logic setf);
    @(negedge clk);
    opcode = op; wide_mode = wd; shamt = sh; op_a = a; op_b = b; set_flags = setf;
    #1;
  endtask

  task automatic finish_op();
    @(posedge clk);
    @(negedge clk);
    set_flags = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_flags("R10 reset", 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VECS[i].op, VECS[i].wide, VECS[i].sh, VECS[i].a, VECS[i].b, 1'b1);
      check_res($sformatf("R1 vec%0d", i), VECS[i].res);
      finish_op();
      check_flags($sformatf("R2-chain vec%0d", i), VECS[i].nzcv);
    end

    // R9: overflowing add with set_flags low leaves flags 1000 untouched
    run_op(3'd3, 1'b0, 5'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    check_res("R9 result", 32'hFFFF_FFFE);
    finish_op();
    check_flags("R9 hold", 4'b1000);

    // R1: opcode 7 behaves as AND
    run_op(3'd7, 1'b0, 5'd0, 32'h0000_F0F0, 32'h0000_FF00, 1'b0);
    check_res("R1 opcode7", 32'h0000_F000);
    finish_op();

    // R5: shift 31 takes bit 1 of B
    run_op(3'd1, 1'b0, 5'd31, 32'h0000_0000, 32'h0000_0002, 1'b1);
    check_res("R5 sh31 result", 32'h0000_0000);
    finish_op();
    check_flags("R5 sh31", 4'b0110);

    // R8: wide mode clears C even when a 1 is shifted out
    run_op(3'd0, 1'b1, 5'd31, 32'hFFFF_FFFF, 32'h0000_0003, 1'b1);
    check_res("R8 result", 32'h8000_0000);
    finish_op();
    check_flags("R8 wide shift", 4'b1000);

    // R10: flags do not change before the rising edge
    run_op(3'd4, 1'b0, 5'd0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    check_flags("R10 pre-edge", 4'b1000);
    finish_op();
    check_flags("R10 post-edge", 4'b0110);

    // R10: reset mid-run clears flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_flags("R10 async reset", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    summary();
  end
endmodule